// File: doc/BRIEF.md
# Keyboard Port Trap and Gate-Passthrough Sequencer

This block sits beside the host I/O decode of a legacy chipset and watches every I/O cycle aimed at the keyboard-controller data port (60h) and command/status port (64h). Software sets per-port, per-direction enables, and an enabled access is trapped: the block flags the trap in the cycle of the access, issues a one-cycle system-management interrupt (SMI) request on the following clock, and records the port and direction in a status flag that software clears by writing 1.

A further enable turns a USB interrupt edge into an SMI request. A passthrough enable lets the block recognise the address-line-20 gate command sequence and let it through untrapped. The sequence is a D1h command write to 64h, then any data write to 60h, then any number of 64h status reads, and it ends with an FFh write to 64h. While that sequence runs, no trap, SMI or status update occurs. The first access that does not fit the next step aborts the sequence, and that access is handled as an ordinary one.

Top module: `kbd_trap_seq`

## Requirements
- R1: After reset every enable is 0, statusFlags is 0, trapHit and smiReq are low, and an access to 60h or 64h is not trapped.
- R2: The enable register is written with cfgWe=1, cfgSel=0 and takes effect from the next cycle. Its bits are: bit0 trap 60h reads, bit1 trap 60h writes, bit2 trap 64h reads, bit3 trap 64h writes, bit4 SMI on USB interrupt, bit5 passthrough. An access (ioStrobe=1, ioWrite=1 for write) that matches an enabled port and direction drives trapHit high in the same cycle. An access with the other direction does not.
- R3: smiReq is high for exactly the one cycle after each trapped access.
- R4: statusFlags uses the same bit order as enable bits 0 to 3. A flag is set in the cycle after a trap of that port and direction. It is cleared by a write with cfgWe=1, cfgSel=1 that has 1 in that bit of cfgWData.
- R5: With bit4 set, the first cycle in which usbIrq is sampled high after being low raises smiReq for one cycle after that edge, and holding usbIrq high raises nothing more. No USB SMI is raised while a passthrough sequence is in progress.
- R6: An access to any port other than 60h or 64h is never trapped and does not change the sequence state.
- R7: With bit5 set, the sequence of a 64h write of D1h, a 60h write of any value, zero or more 64h reads, and a 64h write of FFh produces no trapHit, no smiReq and no status flag, even with all trap enables set. After it ends, accesses are trapped normally.
- R8: An access to 60h or 64h that is not the next expected step ends the sequence at once and is itself trapped when its enable is set. The next access is judged from idle.
- R9: Clearing bit5 mid-sequence returns the recogniser to idle, and following accesses are trapped normally. With bit5 clear, a D1h write to 64h is trapped when bit3 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioStrobe | input | 1 | One-cycle I/O access strobe |
| ioWrite | input | 1 | 1 = write access, 0 = read access |
| ioAddr | input | 8 | I/O port address |
| ioWData | input | 8 | Write data of the access |
| usbIrq | input | 1 | USB interrupt line |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 1 | 0 = enable register, 1 = status clear |
| cfgWData | input | 8 | Configuration write data |
| trapHit | output | 1 | Access trapped, same cycle as access |
| smiReq | output | 1 | Registered one-cycle SMI request |
| statusFlags | output | 4 | Sticky trap cause flags |

## Verification
trapHit is combinational, so the bench samples it one time unit after driving an access, while the access is still on the inputs and before the capturing edge. smiReq and statusFlags change on the edge that captures the access or the USB edge, so the bench samples them one time unit after that edge. It then samples smiReq again one cycle later to confirm the pulse lasts a single cycle. Configuration writes are applied a full cycle before the accesses that depend on them.

// File: rtl/kbd_trap_pkg.sv
package kbd_trap_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam int N_TRAP = 4;
  localparam int EN_W = N_TRAP + 2;
  localparam int EN_USB = N_TRAP;
  localparam int EN_PASS = N_TRAP + 1;

  typedef enum logic [1:0] {
    SEQ_IDLE     = 2'd0,
    SEQ_GOT_CMD  = 2'd1,
    SEQ_GOT_DATA = 2'd2
  } seqStateT;

  typedef struct packed {
    logic hit60;
    logic hit64;
    logic isWr;
    logic isStart;
    logic isEnd;
  } accessT;

  typedef struct packed {
    logic seqMatch;
    logic seqBusy;
  } seqCtrlT;
endpackage

// File: rtl/kbd_seq_ctrl.sv
module kbd_seq_ctrl
  import kbd_trap_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    passEn,
  input  accessT  acc,
  output seqCtrlT ctrl
);
  seqStateT state, stateNxt;
  logic match;

  always_comb begin
    match = 1'b0;
    stateNxt = state;
    if (!passEn) begin
      stateNxt = SEQ_IDLE;
    end else if (acc.hit60 || acc.hit64) begin
      case (state)
        SEQ_IDLE: begin
          if (acc.hit64 && acc.isWr && acc.isStart) begin
            match = 1'b1;
            stateNxt = SEQ_GOT_CMD;
          end
        end
        SEQ_GOT_CMD: begin
          if (acc.hit60 && acc.isWr) begin
            match = 1'b1;
            stateNxt = SEQ_GOT_DATA;
          end else begin
            stateNxt = SEQ_IDLE;
          end
        end
        SEQ_GOT_DATA: begin
          if (acc.hit64 && !acc.isWr) begin
            match = 1'b1;
          end else if (acc.hit64 && acc.isWr && acc.isEnd) begin
            match = 1'b1;
            stateNxt = SEQ_IDLE;
          end else begin
            stateNxt = SEQ_IDLE;
          end
        end
        default: stateNxt = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= SEQ_IDLE;
    else state <= stateNxt;
  end

  assign ctrl.seqMatch = match;
  assign ctrl.seqBusy = (state != SEQ_IDLE);

  // R7
  seq_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctrl.seqBusy) |-> $past(acc.hit64 && acc.isWr && acc.isStart && passEn));

  // R9
  pass_off_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !passEn |=> !ctrl.seqBusy);

  // R6
  other_port_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (passEn && !acc.hit60 && !acc.hit64) |=> $stable(state));
endmodule

// File: rtl/kbd_trap_dp.sv
module kbd_trap_dp
  import kbd_trap_pkg::*;
#(
  parameter logic [ADDR_W-1:0] DATA_PORT = 8'h60,
  parameter logic [ADDR_W-1:0] CMD_PORT = 8'h64,
  parameter logic [DATA_W-1:0] START_CODE = 8'hD1,
  parameter logic [DATA_W-1:0] END_CODE = 8'hFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioStrobe,
  input  logic              ioWrite,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [DATA_W-1:0] ioWData,
  input  logic              usbIrq,
  input  logic              cfgWe,
  input  logic              cfgSel,
  input  logic [DATA_W-1:0] cfgWData,
  input  seqCtrlT           ctrl,
  output accessT            acc,
  output logic              passEn,
  output logic              trapHit,
  output logic              smiReq,
  output logic [N_TRAP-1:0] statusFlags
);
  logic [EN_W-1:0] enReg;
  logic [N_TRAP-1:0] portSel, trapVec;
  logic usbIrqD, usbRise;

  assign acc.hit60 = ioStrobe && (ioAddr == DATA_PORT);
  assign acc.hit64 = ioStrobe && (ioAddr == CMD_PORT);
  assign acc.isWr = ioWrite;
  assign acc.isStart = (ioWData == START_CODE);
  assign acc.isEnd = (ioWData == END_CODE);

  assign portSel = {acc.hit64 && ioWrite, acc.hit64 && !ioWrite,
                    acc.hit60 && ioWrite, acc.hit60 && !ioWrite};
  assign passEn = enReg[EN_PASS];
  assign usbRise = usbIrq && !usbIrqD;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg <= '0;
      usbIrqD <= 1'b0;
      smiReq <= 1'b0;
    end else begin
      if (cfgWe && !cfgSel) enReg <= cfgWData[EN_W-1:0];
      usbIrqD <= usbIrq;
      smiReq <= trapHit || (usbRise && enReg[EN_USB] && !ctrl.seqBusy);
    end
  end

  for (genvar i = 0; i < N_TRAP; i++) begin : g_trap
    assign trapVec[i] = portSel[i] && enReg[i] && !ctrl.seqMatch;
    always_ff @(posedge clk) begin
      if (!rstN) statusFlags[i] <= 1'b0;
      else if (trapVec[i]) statusFlags[i] <= 1'b1;
      else if (cfgWe && cfgSel && cfgWData[i]) statusFlags[i] <= 1'b0;
    end
  end

  assign trapHit = |trapVec;

  // R6
  other_port_notrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ioStrobe && ioAddr != DATA_PORT && ioAddr != CMD_PORT) |-> !trapHit);

  // R7
  seq_no_trap_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.seqMatch |-> !trapHit);

  // R3
  smi_after_trap_chk: assert property (@(posedge clk) disable iff (!rstN)
    trapHit |=> smiReq);

  // R4
  status_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(statusFlags & ~$past(statusFlags))) |-> $past(trapHit));
endmodule

// File: rtl/kbd_trap_seq.sv
module kbd_trap_seq
  import kbd_trap_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ioStrobe,
  input  logic        ioWrite,
  input  logic [7:0]  ioAddr,
  input  logic [7:0]  ioWData,
  input  logic        usbIrq,
  input  logic        cfgWe,
  input  logic        cfgSel,
  input  logic [7:0]  cfgWData,
  output logic        trapHit,
  output logic        smiReq,
  output logic [3:0]  statusFlags
);
  accessT acc;
  seqCtrlT ctrl;
  logic passEn;

  kbd_trap_dp u_dp (
    .clk(clk), .rstN(rstN), .ioStrobe(ioStrobe), .ioWrite(ioWrite),
    .ioAddr(ioAddr), .ioWData(ioWData), .usbIrq(usbIrq), .cfgWe(cfgWe),
    .cfgSel(cfgSel), .cfgWData(cfgWData), .ctrl(ctrl), .acc(acc),
    .passEn(passEn), .trapHit(trapHit), .smiReq(smiReq),
    .statusFlags(statusFlags)
  );

  kbd_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .passEn(passEn), .acc(acc), .ctrl(ctrl)
  );
endmodule

// File: tb/kbd_trap_seq_test.sv
module kbd_trap_seq_test;
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic ioStrobe = 0, ioWrite = 0, usbIrq = 0, cfgWe = 0, cfgSel = 0;
  logic [7:0] ioAddr = 0, ioWData = 0, cfgWData = 0;
  logic trapHit, smiReq;
  logic [3:0] statusFlags;
  int nRun = 0, nFail = 0;
  logic t, s;

  always #(CLK_PERIOD/2) clk = ~clk;

  kbd_trap_seq uut (
    .clk(clk), .rstN(rstN), .ioStrobe(ioStrobe), .ioWrite(ioWrite),
    .ioAddr(ioAddr), .ioWData(ioWData), .usbIrq(usbIrq), .cfgWe(cfgWe),
    .cfgSel(cfgSel), .cfgWData(cfgWData), .trapHit(trapHit),
    .smiReq(smiReq), .statusFlags(statusFlags)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one access; t = trapHit during the access, s = smiReq after the edge
  task automatic doIo(input logic wr, input logic [7:0] a, input logic [7:0] d,
                      output logic tr, output logic sm);
    @(negedge clk);
    ioStrobe = 1; ioWrite = wr; ioAddr = a; ioWData = d;
    #1 tr = trapHit;
    @(posedge clk); #1 sm = smiReq;
    @(negedge clk);
    ioStrobe = 0;
  endtask

  task automatic cfgWrite(input logic sel, input logic [7:0] d);
    @(negedge clk);
    cfgWe = 1; cfgSel = sel; cfgWData = d;
    @(negedge clk);
    cfgWe = 0;
  endtask

  task automatic testReset();
    check("R1 reset status", {4'h0, statusFlags}, 8'h00);
    check("R1 reset trap", {7'h0, trapHit}, 8'h00);
    check("R1 reset smi", {7'h0, smiReq}, 8'h00);
    doIo(1, 8'h64, 8'h12, t, s);
    check("R1 no trap with enables 0", {6'h0, t, s}, 8'h00);
  endtask

  task automatic testEnables();
    logic [7:0] addrs [4] = '{8'h60, 8'h60, 8'h64, 8'h64};
    for (int i = 0; i < 4; i++) begin
      cfgWrite(0, 8'(1 << i));
      doIo(i[0], addrs[i], 8'h00, t, s);
      check($sformatf("R2 trap bit%0d", i), {7'h0, t}, 8'h01);
      check($sformatf("R3 smi bit%0d", i), {7'h0, s}, 8'h01);
      check($sformatf("R4 status bit%0d", i), {4'h0, statusFlags}, 8'(1 << i));
      @(posedge clk); #1;
      check($sformatf("R3 smi one cycle bit%0d", i), {7'h0, smiReq}, 8'h00);
      doIo(!i[0], addrs[i], 8'h00, t, s);
      check($sformatf("R2 other direction bit%0d", i), {6'h0, t, s}, 8'h00);
      cfgWrite(1, 8'h0F);
      check($sformatf("R4 clear bit%0d", i), {4'h0, statusFlags}, 8'h00);
    end
  endtask

  task automatic testOtherPort();
    cfgWrite(0, 8'h0F);
    doIo(1, 8'h61, 8'h00, t, s);
    check("R6 port 61h write", {6'h0, t, s}, 8'h00);
    doIo(0, 8'h65, 8'h00, t, s);
    check("R6 port 65h read", {6'h0, t, s}, 8'h00);
    check("R6 status untouched", {4'h0, statusFlags}, 8'h00);
  endtask

  task automatic testSequence();
    cfgWrite(0, 8'h3F);
    doIo(1, 8'h64, 8'hD1, t, s); check("R7 start", {6'h0, t, s}, 8'h00);
    doIo(1, 8'h61, 8'h00, t, s); check("R6 foreign mid-seq", {6'h0, t, s}, 8'h00);
    doIo(1, 8'h60, 8'hDF, t, s); check("R7 data", {6'h0, t, s}, 8'h00);
    doIo(0, 8'h64, 8'h00, t, s); check("R7 read 1", {6'h0, t, s}, 8'h00);
    doIo(0, 8'h64, 8'h00, t, s); check("R7 read 2", {6'h0, t, s}, 8'h00);
    doIo(1, 8'h64, 8'hFF, t, s); check("R7 end", {6'h0, t, s}, 8'h00);
    check("R7 no status", {4'h0, statusFlags}, 8'h00);
    doIo(0, 8'h64, 8'h00, t, s); check("R7 trap after end", {6'h0, t, s}, 8'h03);
    cfgWrite(1, 8'h0F);
    doIo(1, 8'h64, 8'hD1, t, s);
    doIo(1, 8'h60, 8'h00, t, s);
    doIo(1, 8'h64, 8'hFF, t, s); check("R7 no-read sequence end", {6'h0, t, s}, 8'h00);
    check("R7 no-read status", {4'h0, statusFlags}, 8'h00);
  endtask

  task automatic testDeviation();
    cfgWrite(0, 8'h3F);
    doIo(1, 8'h64, 8'hD1, t, s);
    doIo(0, 8'h64, 8'h00, t, s); check("R8 deviation after start", {6'h0, t, s}, 8'h03);
    check("R8 deviation status", {4'h0, statusFlags}, 8'h04);
    doIo(1, 8'h60, 8'h00, t, s); check("R8 back to idle", {6'h0, t, s}, 8'h03);
    cfgWrite(1, 8'h0F);
    doIo(1, 8'h64, 8'hD1, t, s);
    doIo(1, 8'h60, 8'h00, t, s);
    doIo(0, 8'h60, 8'h00, t, s); check("R8 deviation after data", {6'h0, t, s}, 8'h03);
    doIo(1, 8'h64, 8'hFF, t, s); check("R8 end code from idle", {6'h0, t, s}, 8'h03);
    cfgWrite(1, 8'h0F);
  endtask

  task automatic testPassOff();
    cfgWrite(0, 8'h3F);
    doIo(1, 8'h64, 8'hD1, t, s);
    cfgWrite(0, 8'h0F);
    doIo(1, 8'h60, 8'h00, t, s); check("R9 idle after pass off", {6'h0, t, s}, 8'h03);
    doIo(1, 8'h64, 8'hD1, t, s); check("R9 start trapped when off", {6'h0, t, s}, 8'h03);
    cfgWrite(1, 8'h0F);
  endtask

  task automatic testUsb();
    cfgWrite(0, 8'h30);
    @(negedge clk); usbIrq = 1;
    @(posedge clk); #1 check("R5 usb smi", {7'h0, smiReq}, 8'h01);
    check("R5 usb no trap", {7'h0, trapHit}, 8'h00);
    @(posedge clk); #1 check("R5 usb held no repeat", {7'h0, smiReq}, 8'h00);
    @(negedge clk); usbIrq = 0;
    doIo(1, 8'h64, 8'hD1, t, s);
    @(negedge clk); usbIrq = 1;
    @(posedge clk); #1 check("R5 usb masked in sequence", {7'h0, smiReq}, 8'h00);
    @(negedge clk); usbIrq = 0;
    doIo(1, 8'h60, 8'h00, t, s);
    doIo(1, 8'h64, 8'hFF, t, s);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    @(negedge clk);
    testReset();
    testEnables();
    testOtherPort();
    testSequence();
    testDeviation();
    testPassOff();
    testUsb();
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    nRun++; nFail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule